// File: doc/BRIEF.md
# Video Field Timing Generator

This block derives line and field timing for a composite video encoder from a single pixel-rate clock. It keeps a count of half-lines within the current field. Each field lasts a whole number of half-lines, and that number depends on the selected frame rate (50 Hz or 60 Hz) and on a 2-bit length control. From this count the block raises a one-clock line strobe, a one-clock field strobe, a field-identity bit, a colour-subcarrier phase-reset pulse on a programmable schedule, and a blanking flag.

With no external sync the counter runs freely. When a rising edge arrives on the vertical sync input, the counter is reloaded so that the next field boundary lands a fixed number of half-lines later. That number is the trigger span, 32 by default, less a 5-bit trigger offset. A larger offset therefore brings every generated signal earlier. The block carries no pixel data, so it has no valid/ready stream interface: every pin is a plain control or status level or pulse. Length, rate and subcarrier schedule are taken in only at field boundaries, so the block never cuts a field short.

Top module: `field_timing_gen`

## Requirements
- R1: While reset is asserted, every output is 0. The length control, rate select and subcarrier schedule come out of reset as 0 (interlaced, 50 Hz, no subcarrier reset).
- R2: Between sync events, `line_stb_o` pulses once every LINE_CLKS clocks.
- R3: A field lasts H half-lines, which is H*LINE_CLKS/2 clocks between field strobes. At 50 Hz, H is 625 for length control 0, 624 for control 1, and 626 for controls 2 and 3. At 60 Hz the same controls give 525, 524 and 526.
- R4: At each field boundary where the new length control is 0, `field_id_o` toggles. At a boundary where the new control is 1, 2 or 3, it goes to 0. It changes at no other time.
- R5: A change to the length control, rate select or subcarrier schedule has no effect on the field in progress. It takes hold at the next field boundary.
- R6: Suppose `vsync_i` is first seen high at clock edge E0. The next field strobe is then high in the cycle after edge E0 + (32 - offset)*LINE_CLKS/2, where offset is `trig_ofs_i` sampled at E0.
- R7: Subcarrier schedule 0 produces no `scr_stb_o` pulse. Schedule 1 produces a pulse on every second line strobe, so pulses are 2*LINE_CLKS clocks apart and each one coincides with a line strobe.
- R8: Schedule 2 produces a pulse on every eighth field strobe and schedule 3 on every fourth. Each pulse coincides with a field strobe.
- R9: `blank_o` is high for the first 40 half-lines of each field, starting in the cycle of the field strobe. That is 40*LINE_CLKS/2 consecutive clocks.
- R10: When `blank_force_i` is high at a clock edge, `blank_o` is high in the following cycle, whatever the field position.
- R11: The line strobe, field strobe and subcarrier pulse never stay high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate60_i | input | 1 | 1 selects 60 Hz line counts, 0 selects 50 Hz |
| flc_i | input | 2 | Field length control |
| trig_ofs_i | input | 5 | Vertical trigger offset in half-lines |
| scr_mode_i | input | 2 | Subcarrier reset schedule |
| blank_force_i | input | 1 | Forces the blanking flag high |
| vsync_i | input | 1 | External vertical sync; its rising edge reloads the counter |
| line_stb_o | output | 1 | One-cycle pulse at each line start |
| field_stb_o | output | 1 | One-cycle pulse at each field start |
| field_id_o | output | 1 | Field identity |
| scr_stb_o | output | 1 | One-cycle subcarrier phase-reset pulse |
| blank_o | output | 1 | Blanking flag |

## Verification
The hardest case to reach is the eight-field subcarrier schedule. A pulse only shows after up to eight field boundaries have passed with the schedule already latched. The bench makes this reachable by building the block with an eight-clock line, which keeps each field to a few thousand cycles. It then waits for one pulse and counts field strobes up to the next. Deferred configuration is just as easy to miss. To catch it, the bench changes the control inputs on the falling edge right after a field strobe and measures two field periods in a row: the first must still have the old length, the second the new one.

// File: rtl/ft_pkg.sv
package ft_pkg;

  // Width of the half-line counter; covers the longest field (626).
  localparam int HL_W = 10;

  typedef enum logic [1:0] {
    SCR_OFF    = 2'd0,
    SCR_LINE2  = 2'd1,
    SCR_FIELD8 = 2'd2,
    SCR_FIELD4 = 2'd3
  } scr_mode_e;

  typedef struct packed {
    logic      rate60;
    logic [1:0] flc;
    scr_mode_e scr;
  } ft_cfg_t;

  // Half-lines per field for a rate / length-control pair.
  function automatic logic [HL_W-1:0] field_halflines(input logic rate60,
                                                      input logic [1:0] flc);
    logic [HL_W-1:0] nominal;
    nominal = rate60 ? HL_W'(525) : HL_W'(625);
    case (flc)
      2'd0:    return nominal;
      2'd1:    return nominal - HL_W'(1);
      default: return nominal + HL_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/ft_half_div.sv
module ft_half_div #(
  parameter int HALF = 864
) (
  input  logic clk,
  input  logic rst_n,
  input  logic resync,
  output logic tick
);
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          div_q <= '0;
    else if (resync)     div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                 div_q <= div_q + DW'(1);
  end

  // Half-line tick on the last clock of each half-line; a resync restarts it.
  assign tick = (div_q == LAST) && !resync;
endmodule

// File: rtl/ft_halfline_ctr.sv
module ft_halfline_ctr
  import ft_pkg::*;
#(
  parameter int TRIG_SPAN = 32,
  parameter int OFS_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             resync,
  input  logic [OFS_W-1:0] ofs,
  input  logic [HL_W-1:0]  len,
  output logic [HL_W-1:0]  hl_nxt,
  output logic             line_edge,
  output logic             field_edge
);
  logic [HL_W-1:0] hl_q;
  logic            hpar_q;    // 1 on the second half of a line
  logic [HL_W-1:0] load_val;
  logic            par_load;
  logic            at_end;

  // Reload so the wrap comes TRIG_SPAN - ofs half-lines after the sync.
  assign load_val = len - HL_W'(TRIG_SPAN) + HL_W'(ofs);
  // The last tick before the wrap must close a line.
  assign par_load = 1'(TRIG_SPAN) ^ ofs[0];
  assign at_end   = (hl_q == len - HL_W'(1));

  always_comb begin
    hl_nxt = hl_q;
    if (resync)    hl_nxt = load_val;
    else if (tick) hl_nxt = at_end ? '0 : hl_q + HL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hl_q   <= '0;
      hpar_q <= 1'b0;
    end else begin
      hl_q <= hl_nxt;
      if (resync)    hpar_q <= par_load;
      else if (tick) hpar_q <= ~hpar_q;
    end
  end

  assign line_edge  = tick && hpar_q;
  assign field_edge = tick && at_end;
endmodule

// File: rtl/ft_pulse_gen.sv
module ft_pulse_gen
  import ft_pkg::*;
#(
  parameter int VBI_HL = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_edge,
  input  logic            field_edge,
  input  logic            next_interlaced,
  input  scr_mode_e       scr_mode,
  input  logic [HL_W-1:0] hl_nxt,
  input  logic            blank_force,
  output logic            line_stb,
  output logic            field_stb,
  output logic            field_id,
  output logic            scr_stb,
  output logic            blank
);
  logic       lpar_q;
  logic [2:0] fcnt_q;
  logic       scr_d;

  always_comb begin
    unique case (scr_mode)
      SCR_OFF:    scr_d = 1'b0;
      SCR_LINE2:  scr_d = line_edge && lpar_q;
      SCR_FIELD8: scr_d = field_edge && (fcnt_q == 3'd7);
      SCR_FIELD4: scr_d = field_edge && (fcnt_q[1:0] == 2'd3);
      default:    scr_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lpar_q    <= 1'b0;
      fcnt_q    <= '0;
      line_stb  <= 1'b0;
      field_stb <= 1'b0;
      field_id  <= 1'b0;
      scr_stb   <= 1'b0;
      blank     <= 1'b0;
    end else begin
      line_stb  <= line_edge;
      field_stb <= field_edge;
      scr_stb   <= scr_d;
      blank     <= blank_force || (hl_nxt < HL_W'(VBI_HL));
      if (line_edge) lpar_q <= ~lpar_q;
      if (field_edge) begin
        fcnt_q   <= fcnt_q + 3'd1;
        field_id <= next_interlaced ? ~field_id : 1'b0;
      end
    end
  end
endmodule

// File: rtl/field_timing_gen.sv
module field_timing_gen
  import ft_pkg::*;
#(
  parameter int LINE_CLKS = 1728,
  parameter int TRIG_SPAN = 32,
  parameter int OFS_W     = 5,
  parameter int VBI_HL    = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate60_i,
  input  logic [1:0]       flc_i,
  input  logic [OFS_W-1:0] trig_ofs_i,
  input  logic [1:0]       scr_mode_i,
  input  logic             blank_force_i,
  input  logic             vsync_i,
  output logic             line_stb_o,
  output logic             field_stb_o,
  output logic             field_id_o,
  output logic             scr_stb_o,
  output logic             blank_o
);
  localparam int HALF = LINE_CLKS / 2;

  ft_cfg_t         cfg_q;
  logic            vs_q;
  logic            resync;
  logic            tick;
  logic [HL_W-1:0] len;
  logic [HL_W-1:0] hl_nxt;
  logic            line_edge;
  logic            field_edge;

  assign resync = vsync_i && !vs_q;
  assign len    = field_halflines(cfg_q.rate60, cfg_q.flc);

  // Controls are adopted only where a field ends.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q  <= 1'b0;
      cfg_q <= '{rate60: 1'b0, flc: 2'd0, scr: SCR_OFF};
    end else begin
      vs_q <= vsync_i;
      if (field_edge)
        cfg_q <= '{rate60: rate60_i, flc: flc_i, scr: scr_mode_e'(scr_mode_i)};
    end
  end

  ft_half_div #(.HALF(HALF)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .resync (resync),
    .tick   (tick)
  );

  ft_halfline_ctr #(.TRIG_SPAN(TRIG_SPAN), .OFS_W(OFS_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .resync     (resync),
    .ofs        (trig_ofs_i),
    .len        (len),
    .hl_nxt     (hl_nxt),
    .line_edge  (line_edge),
    .field_edge (field_edge)
  );

  ft_pulse_gen #(.VBI_HL(VBI_HL)) u_pulse (
    .clk             (clk),
    .rst_n           (rst_n),
    .line_edge       (line_edge),
    .field_edge      (field_edge),
    .next_interlaced (flc_i == 2'd0),
    .scr_mode        (cfg_q.scr),
    .hl_nxt          (hl_nxt),
    .blank_force     (blank_force_i),
    .line_stb        (line_stb_o),
    .field_stb       (field_stb_o),
    .field_id        (field_id_o),
    .scr_stb         (scr_stb_o),
    .blank           (blank_o)
  );
endmodule

// File: rtl/ft_checker.sv
module ft_checker (
  input logic clk,
  input logic rst_n,
  input logic line_stb_o,
  input logic field_stb_o,
  input logic field_id_o,
  input logic scr_stb_o,
  input logic blank_o,
  input logic blank_force_i
);
  assert_line_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb_o |=> !line_stb_o);

  assert_field_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    field_stb_o |=> !field_stb_o);

  assert_scr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    scr_stb_o |=> !scr_stb_o);

  assert_fid_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (field_id_o != $past(field_id_o)) |-> field_stb_o);

  // R7 / R8: every subcarrier pulse sits on a line or field strobe.
  assert_scr_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scr_stb_o |-> (line_stb_o || field_stb_o));

  assert_force_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    blank_force_i |=> blank_o);

  assert_field_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    field_stb_o |-> blank_o);
endmodule

bind field_timing_gen ft_checker u_ft_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .line_stb_o    (line_stb_o),
  .field_stb_o   (field_stb_o),
  .field_id_o    (field_id_o),
  .scr_stb_o     (scr_stb_o),
  .blank_o       (blank_o),
  .blank_force_i (blank_force_i)
);

// File: tb/field_timing_gen_test.sv
module field_timing_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int LC   = 8;
  localparam int HALF = LC / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate60 = 1'b0;
  logic [1:0] flc = 2'd0;
  logic [4:0] ofs = 5'd0;
  logic [1:0] scr = 2'd0;
  logic       bforce = 1'b0;
  logic       vsync = 1'b0;
  logic       line_stb, field_stb, fid, scr_stb, blank;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  field_timing_gen #(.LINE_CLKS(LC)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .rate60_i      (rate60),
    .flc_i         (flc),
    .trig_ofs_i    (ofs),
    .scr_mode_i    (scr),
    .blank_force_i (bforce),
    .vsync_i       (vsync),
    .line_stb_o    (line_stb),
    .field_stb_o   (field_stb),
    .field_id_o    (fid),
    .scr_stb_o     (scr_stb),
    .blank_o       (blank)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_field(output int n);
    n = 0;
    do begin step(); n++; end while (!field_stb);
  endtask

  task automatic test_reset();   // R1
    step();
    chk("R1 outputs in reset", {line_stb, field_stb, fid, scr_stb, blank}, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic test_lines();   // R2, R11
    int n;
    do step(); while (!line_stb);
    for (int i = 0; i < 3; i++) begin
      n = 0;
      do begin step(); n++; if (n == 1) chk("R11 line strobe width", line_stb, 0); end
      while (!line_stb);
      chk("R2 line period", n, LC);
    end
  endtask

  task automatic test_interlaced();   // R3, R4
    int n; logic f;
    wait_field(n);
    f = fid;
    wait_field(n);
    chk("R3 interlaced 50Hz period", n, 625*HALF);
    chk("R4 interlaced toggle", fid, !f);
    wait_field(n);
    chk("R4 interlaced toggle back", fid, f);
  endtask

  task automatic test_lengths();   // R3, R4, R5
    int n; logic f;
    @(negedge clk); flc = 2'd1;
    wait_field(n);
    chk("R5 old length kept", n, 625*HALF);
    chk("R4 non-interlaced id", fid, 0);
    wait_field(n);
    chk("R3 flc1 50Hz period", n, 624*HALF);
    @(negedge clk); flc = 2'd2;
    wait_field(n);
    chk("R5 flc1 kept", n, 624*HALF);
    wait_field(n);
    chk("R3 flc2 50Hz period", n, 626*HALF);
    chk("R4 flc2 id", fid, 0);
    @(negedge clk); flc = 2'd3;
    wait_field(n);
    wait_field(n);
    chk("R3 flc3 50Hz period", n, 626*HALF);
    @(negedge clk); rate60 = 1'b1; flc = 2'd0;
    wait_field(n);
    chk("R5 rate change deferred", n, 626*HALF);
    f = fid;
    wait_field(n);
    chk("R3 interlaced 60Hz period", n, 525*HALF);
    chk("R4 60Hz toggle", fid, !f);
    @(negedge clk); flc = 2'd1;
    wait_field(n);
    wait_field(n);
    chk("R3 flc1 60Hz period", n, 524*HALF);
    @(negedge clk); flc = 2'd2;
    wait_field(n);
    wait_field(n);
    chk("R3 flc2 60Hz period", n, 526*HALF);
  endtask

  task automatic test_scr_line();   // R7
    int n, cnt;
    @(negedge clk); scr = 2'd1;
    wait_field(n);
    do step(); while (!scr_stb);
    chk("R7 pulse on line strobe", line_stb, 1);
    n = 0;
    do begin step(); n++; end while (!scr_stb);
    chk("R7 every second line", n, 2*LC);
    @(negedge clk); scr = 2'd0;
    wait_field(n);
    cnt = 0;
    do begin step(); if (scr_stb) cnt++; end while (!field_stb);
    chk("R7 schedule off", cnt, 0);
  endtask

  task automatic test_scr_field();   // R8
    int n, k;
    @(negedge clk); scr = 2'd2;
    wait_field(n);
    do wait_field(n); while (!scr_stb);
    k = 0;
    do begin wait_field(n); k++; end while (!scr_stb);
    chk("R8 every eighth field", k, 8);
    @(negedge clk); scr = 2'd3;
    wait_field(n);
    do wait_field(n); while (!scr_stb);
    k = 0;
    do begin wait_field(n); k++; end while (!scr_stb);
    chk("R8 every fourth field", k, 4);
    @(negedge clk); scr = 2'd0;
  endtask

  task automatic test_blank();   // R9, R10
    int n;
    wait_field(n);
    chk("R9 blank at field start", blank, 1);
    n = 1;
    forever begin step(); if (!blank) break; n++; end
    chk("R9 blank length", n, 40*HALF);
    repeat (20) step();
    @(negedge clk); bforce = 1'b1;
    step();
    chk("R10 forced blank", blank, 1);
    @(negedge clk); bforce = 1'b0;
    step();
    chk("R10 force released", blank, 0);
  endtask

  task automatic test_vsync(input int off);   // R6
    int n;
    @(negedge clk); ofs = 5'(off); vsync = 1'b1;
    @(posedge clk);
    @(negedge clk); vsync = 1'b0;
    n = 0;
    do begin step(); n++; end while (!field_stb);
    chk($sformatf("R6 sync delay offset %0d", off), n, (32 - off)*HALF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    test_reset();
    test_lines();
    test_interlaced();
    test_lengths();
    test_scr_line();
    test_scr_field();
    test_blank();
    test_vsync(0);
    test_vsync(31);
    test_vsync(5);
    finish_run();
  end
endmodule